// File: doc/BRIEF.md
# Backward In-Place LZ Decompressor

This block expands a byte stream that was compressed with a reverse-order LZ77 scheme. Decoding walks through memory from high addresses to low ones. The compressed bytes sit just below a buffer end address. The decoded bytes are written downward from a point above that address. The output lands in the same memory that holds the input, so each written byte overwrites a compressed byte that has already been read. Below the compressed image lies a short stretch of bytes that were never compressed. These bytes are already final, so decoding ends as soon as the output reaches them.

A controller that has already parsed the stream's trailer supplies three values and pulses `start`:
- the buffer end address (one past the last compressed byte),
- the compressed length,
- the number of extra bytes by which the output grows past the buffer end.

The block then works through one single-port memory using a request/ready handshake. When it finishes, it raises `done`, or it raises `error` if the stream would read or write outside its legal window.

Top module: `lzb_backdec`

## Requirements
- R1: After reset, `busy`, `done`, `error` and `mem_req` are all low.
- R2: Compressed bytes are read starting at `buf_end-1`, at falling addresses. Output bytes are written starting at `buf_end+extra_len-1`, and every write address is strictly below the previous write of the same run.
- R3: A group starts with a flag byte. Its bits are used from bit 7 down to bit 0: a 1 selects a back-reference and a 0 selects a literal. After eight tokens, the next byte read is a new flag byte.
- R4: A back-reference is two bytes. In the first one read (the higher address), the upper nibble L gives a copy length of L+3 (3 to 18). Its lower nibble forms bits 11:8 of a 12-bit field D, and the second byte forms bits 7:0 of D. The copy distance is D+3 (3 to 4098).
- R5: A copy writes one byte per step. Each byte written at address a takes the value currently stored at a+distance, so a copy that overlaps its own output repeats the pattern.
- R6: Decoding ends with `done` when a token completes with the write pointer equal to the base, `buf_end-comp_len`. Bytes below the base and bytes at or above `buf_end+extra_len` are never written.
- R7: If a write would land below the lowest compressed byte already read, the block raises `error` and stops without writing.
- R8: If a compressed byte is needed while the read pointer already sits at the base, the block raises `error` and stops without reading.
- R9: If a copy source address would be at or above `buf_end+extra_len`, the block raises `error` and stops.
- R10: `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` hold steady until `mem_ready` is seen high. Read data is taken from `mem_rdata` in the cycle after acceptance.
- R11: `done` and `error` never appear together, and each holds until the next `start`. A `start` pulse during a run is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run (ignored while busy) |
| buf_end | input | AW | One past the highest compressed byte |
| comp_len | input | AW | Number of compressed bytes |
| extra_len | input | AW | Output growth above `buf_end` |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished normally |
| error | output | 1 | Run stopped on a bounds violation |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Byte address |
| mem_wdata | output | 8 | Write data |
| mem_ready | input | 1 | Request accepted this cycle |
| mem_rdata | input | 8 | Read data, valid the cycle after a read is accepted |

## Verification
The hardest case to reach from the ports is a far back-reference that uses the maximum 12-bit distance field. Building it needs more than four thousand decoded bytes in which the only match is exactly 4098 bytes away.

The bench builds such an image on purpose. It places a pseudo-random block, follows it with a long constant filler, and then repeats the block. The bench's own encoder searches that distance explicitly, and the bench also checks that the encoder did emit the maximum field.

The in-place overwrite limit is reached with a hand-made stream whose overlapping copy outruns the consumed input. The bench predicts the error outcome for every encoded image from its running read and write counts.

// File: rtl/lzb_pkg.sv
package lzb_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_NEXT, ST_FLAG, ST_LIT, ST_LITW,
    ST_TK1, ST_TK2, ST_CPR, ST_CPW, ST_DONE, ST_ERR
  } lzb_state_e;

  localparam int LEN_BIAS  = 3;
  localparam int DIST_BIAS = 3;

  // copy length from the first token byte (upper nibble plus bias)
  function automatic logic [4:0] tok_len(input logic [7:0] b1);
    return {1'b0, b1[7:4]} + 5'(LEN_BIAS);
  endfunction

  // copy distance: low nibble of first byte is the high part
  function automatic logic [12:0] tok_dist(input logic [7:0] b1, input logic [7:0] b2);
    return {1'b0, b1[3:0], b2} + 13'(DIST_BIAS);
  endfunction

endpackage

// File: rtl/lzb_flagreg.sv
module lzb_flagreg #(
  parameter int FW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          load,
  input  logic [FW-1:0] flag_in,
  input  logic          take,
  output logic          is_ref,
  output logic          empty
);
  localparam int CW = $clog2(FW + 1);

  logic [FW-1:0] sr_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else if (load) begin
      sr_q  <= flag_in;
      cnt_q <= CW'(FW);
    end else if (take) begin
      sr_q  <= sr_q << 1;
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign is_ref = sr_q[FW-1];
  assign empty  = (cnt_q == '0);

  p_cnt_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(FW));
  p_take_nonempty_r3: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> !empty);

endmodule

// File: rtl/lzb_ptrs.sv
module lzb_ptrs #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          init,
  input  logic [AW-1:0] buf_end,
  input  logic [AW-1:0] comp_len,
  input  logic [AW-1:0] extra_len,
  input  logic          rd_step,
  input  logic          wr_step,
  output logic [AW-1:0] rd_ptr,
  output logic [AW-1:0] wr_ptr,
  output logic [AW-1:0] base,
  output logic [AW-1:0] top,
  output logic          rd_ok,
  output logic          wr_ok,
  output logic          at_base
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      base   <= '0;
      top    <= '0;
    end else if (init) begin
      rd_ptr <= buf_end;
      wr_ptr <= buf_end + extra_len;
      base   <= buf_end - comp_len;
      top    <= buf_end + extra_len;
    end else begin
      if (rd_step) rd_ptr <= rd_ptr - 1'b1;
      if (wr_step) wr_ptr <= wr_ptr - 1'b1;
    end
  end

  assign rd_ok   = rd_ptr > base;
  assign wr_ok   = wr_ptr > rd_ptr;
  assign at_base = wr_ptr == base;

  p_rd_floor_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_step |=> rd_ptr >= base);
  p_wr_not_below_rd_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_step |=> wr_ptr >= rd_ptr);

endmodule

// File: rtl/lzb_backdec.sv
module lzb_backdec
  import lzb_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] buf_end,
  input  logic [AW-1:0] comp_len,
  input  logic [AW-1:0] extra_len,
  output logic          busy,
  output logic          done,
  output logic          error,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  input  logic          mem_ready,
  input  logic [7:0]    mem_rdata
);
  localparam int XW = AW + 1;

  lzb_state_e    state;
  logic          pend;
  logic [7:0]    byte_q, b1_q;
  logic [4:0]    len_q;
  logic [12:0]   dist_q;

  logic [AW-1:0] rd_ptr, wr_ptr, base, top;
  logic          rd_ok, wr_ok, at_base;
  logic          is_ref, flags_empty;

  // named events for the assertions and the sub-blocks
  logic          launch, is_rd, is_cprd, is_wr, fire, rd_step, wr_step;
  logic          flag_load, flag_take, src_bad;
  logic [XW-1:0] src;

  function automatic logic [XW-1:0] src_of(input logic [AW-1:0] w, input logic [12:0] d);
    return {1'b0, w} - XW'(1) + {{(XW-13){1'b0}}, d};
  endfunction

  assign busy    = !(state inside {ST_IDLE, ST_DONE, ST_ERR});
  assign done    = state == ST_DONE;
  assign error   = state == ST_ERR;
  assign launch  = start && !busy;
  assign is_rd   = state inside {ST_FLAG, ST_LIT, ST_TK1, ST_TK2};
  assign is_cprd = state == ST_CPR;
  assign is_wr   = state inside {ST_LITW, ST_CPW};
  assign src     = src_of(wr_ptr, dist_q);
  assign src_bad = src >= {1'b0, top};

  assign mem_req   = (is_rd && !pend && rd_ok) || (is_cprd && !pend && !src_bad) || (is_wr && wr_ok);
  assign mem_we    = is_wr;
  assign mem_addr  = is_wr ? wr_ptr - 1'b1 : (is_cprd ? src[AW-1:0] : rd_ptr - 1'b1);
  assign mem_wdata = byte_q;
  assign fire      = mem_req && mem_ready;
  assign rd_step   = fire && is_rd;
  assign wr_step   = fire && is_wr;
  assign flag_load = state == ST_FLAG && pend;
  assign flag_take = state == ST_NEXT && !at_base && !flags_empty;

  lzb_ptrs #(.AW(AW)) u_ptrs (
    .clk(clk), .rst_n(rst_n), .init(launch),
    .buf_end(buf_end), .comp_len(comp_len), .extra_len(extra_len),
    .rd_step(rd_step), .wr_step(wr_step),
    .rd_ptr(rd_ptr), .wr_ptr(wr_ptr), .base(base), .top(top),
    .rd_ok(rd_ok), .wr_ok(wr_ok), .at_base(at_base)
  );

  lzb_flagreg #(.FW(8)) u_flags (
    .clk(clk), .rst_n(rst_n), .clr(launch),
    .load(flag_load), .flag_in(mem_rdata), .take(flag_take),
    .is_ref(is_ref), .empty(flags_empty)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      pend   <= 1'b0;
      byte_q <= '0;
      b1_q   <= '0;
      len_q  <= '0;
      dist_q <= '0;
    end else if (launch) begin
      state <= ST_NEXT;
      pend  <= 1'b0;
    end else begin
      case (state)
        ST_NEXT: begin
          if (at_base)          state <= ST_DONE;
          else if (flags_empty) state <= ST_FLAG;
          else if (is_ref)      state <= ST_TK1;
          else                  state <= ST_LIT;
        end
        ST_FLAG, ST_LIT, ST_TK1, ST_TK2: begin
          if (!pend) begin
            if (!rd_ok)         state <= ST_ERR;
            else if (mem_ready) pend  <= 1'b1;
          end else begin
            pend <= 1'b0;
            case (state)
              ST_FLAG: state <= ST_NEXT;
              ST_LIT:  begin byte_q <= mem_rdata; state <= ST_LITW; end
              ST_TK1:  begin b1_q <= mem_rdata; state <= ST_TK2; end
              default: begin
                len_q  <= tok_len(b1_q);
                dist_q <= tok_dist(b1_q, mem_rdata);
                state  <= ST_CPR;
              end
            endcase
          end
        end
        ST_LITW: begin
          if (!wr_ok)         state <= ST_ERR;
          else if (mem_ready) state <= ST_NEXT;
        end
        ST_CPR: begin
          if (!pend) begin
            if (src_bad)        state <= ST_ERR;
            else if (mem_ready) pend  <= 1'b1;
          end else begin
            pend   <= 1'b0;
            byte_q <= mem_rdata;
            state  <= ST_CPW;
          end
        end
        ST_CPW: begin
          if (!wr_ok) state <= ST_ERR;
          else if (mem_ready) begin
            len_q <= len_q - 1'b1;
            state <= (len_q == 5'd1) ? ST_NEXT : ST_CPR;
          end
        end
        default: state <= state;
      endcase
    end
  end

  // write-order tracker used only by the assertions below
  logic [AW-1:0] last_wr_q;
  logic          have_wr_q;
  always_ff @(posedge clk) begin
    if (!rst_n || launch) begin
      last_wr_q <= '0;
      have_wr_q <= 1'b0;
    end else if (wr_step) begin
      last_wr_q <= mem_addr;
      have_wr_q <= 1'b1;
    end
  end

  p_wr_desc_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_step && have_wr_q |-> mem_addr < last_wr_q);
  p_len_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_CPR |-> len_q >= 5'd1 && len_q <= 5'd18);
  p_wr_above_rd_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> mem_addr >= rd_ptr);
  p_rd_floor_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_we && !is_cprd |-> mem_addr >= base);
  p_src_ceiling_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_we |-> mem_addr < top);
  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));
  p_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && error));
  p_done_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done);

endmodule

// File: tb/lzb_backdec_tb.sv
module lzb_backdec_tb;
  localparam int AW    = 16;
  localparam int MEMSZ = 8192;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] buf_end = '0, comp_len = '0, extra_len = '0;
  logic          busy, done, error, mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [7:0]    mem_wdata;
  logic          mem_ready = 1'b1;
  logic [7:0]    mem_rdata = '0;

  lzb_backdec #(.AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .buf_end(buf_end),
    .comp_len(comp_len), .extra_len(extra_len), .busy(busy), .done(done),
    .error(error), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata)
  );

  logic [7:0] mem   [MEMSZ];
  logic [7:0] plain [4200];
  logic [7:0] cs    [4800];
  int cn, minrw, n_chk, n_bad, desc_bad, hold_bad;
  bit used_far, stall_mode;
  logic [15:0] lfsr = 16'hACE1;
  logic [AW-1:0] last_wr, prev_addr;
  bit have_wr, prev_wait;

  // memory model and port monitors
  always @(posedge clk) begin
    if (mem_req && mem_ready) begin
      if (mem_we) mem[mem_addr[12:0]] <= mem_wdata;
      else        mem_rdata <= mem[mem_addr[12:0]];
    end
    if (start && !busy) have_wr <= 1'b0;
    else if (mem_req && mem_we && mem_ready) begin
      if (have_wr && mem_addr >= last_wr) desc_bad <= desc_bad + 1;
      last_wr <= mem_addr;
      have_wr <= 1'b1;
    end
    if (prev_wait && (!mem_req || mem_addr != prev_addr)) hold_bad <= hold_bad + 1;
    prev_wait <= mem_req && !mem_ready;
    prev_addr <= mem_addr;
  end

  always @(negedge clk) begin
    lfsr      <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    mem_ready <= stall_mode ? (lfsr[0] | lfsr[3]) : 1'b1;
  end

  function automatic logic [7:0] fillv(input int a);
    return (8'(a) ^ (8'(a >> 8) * 8'd3)) ^ 8'h5A;
  endfunction

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  // greedy encoder in decode order; records min(reads-writes) before each write
  task automatic encode(input int n, input int maxd, input bit far);
    int j, r, w;
    cn = 0; j = 0; r = 0; w = 0; minrw = 1000000; used_far = 0;
    while (j < n) begin
      int fpos;
      fpos = cn; cs[cn] = 8'h00; cn++; r++;
      for (int b = 0; b < 8 && j < n; b++) begin
        int bl, bd;
        bl = 0; bd = 0;
        for (int d = 3; d <= maxd && d <= j; d++) begin
          int l;
          if (far && d > 64 && d < 4098) continue;
          l = 0;
          while (l < 18 && j + l < n && plain[j+l] == plain[j+l-d]) l++;
          if (l > bl) begin bl = l; bd = d; end
        end
        if (bl >= 3) begin
          logic [3:0]  lf;
          logic [11:0] df;
          lf = 4'(bl - 3); df = 12'(bd - 3);
          if (bd == 4098) used_far = 1;
          cs[fpos] = cs[fpos] | (8'h80 >> b);
          cs[cn] = {lf, df[11:8]}; cs[cn+1] = df[7:0]; cn += 2; r += 2;
          for (int k = 0; k < bl; k++) begin
            if (r - w < minrw) minrw = r - w;
            w++;
          end
          j += bl;
        end else begin
          cs[cn] = plain[j]; cn++; r++;
          if (r - w < minrw) minrw = r - w;
          w++; j++;
        end
      end
    end
  endtask

  task automatic launch_run(input int be, input int ext, input bit poke);
    for (int a = 0; a < MEMSZ; a++) mem[a] = fillv(a);
    for (int k = 0; k < cn; k++) mem[be-1-k] = cs[k];
    @(negedge clk);
    buf_end = AW'(be); comp_len = AW'(cn); extra_len = AW'(ext);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (40) @(negedge clk);
      buf_end = '0; comp_len = '0; extra_len = '0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    for (int c = 0; c < 60000 && !done && !error; c++) @(negedge clk);
  endtask

  // full case from plain[]; verifies output, untouched borders and ordering
  task automatic run_case(input string rq, input int n, input int be, input int maxd, input bit far, input bit poke);
    int ext, base, top, bad;
    bit exp_err;
    encode(n, maxd, far);
    ext = n - cn;
    chk(ext >= 0, rq, "image compresses", ext, 0);
    base = be - cn; top = be + ext;
    exp_err = (ext + minrw < 1);
    desc_bad = 0; hold_bad = 0;
    launch_run(be, ext, poke);
    chk(done == !exp_err, "R6", "done flag", int'(done), int'(!exp_err));
    chk(error == exp_err, "R7", "error flag", int'(error), int'(exp_err));
    bad = 0;
    if (!exp_err)
      for (int j = 0; j < n; j++) if (mem[top-1-j] != plain[j]) bad++;
    chk(bad == 0, rq, "decoded bytes mismatching", bad, 0);
    bad = 0;
    for (int a = base - 21; a < base; a++) if (mem[a] != fillv(a)) bad++;
    if (mem[top] != fillv(top)) bad++;
    chk(bad == 0, "R6", "bytes outside window changed", bad, 0);
    chk(desc_bad == 0, "R2", "non-descending writes", desc_bad, 0);
    chk(hold_bad == 0, "R10", "request dropped while waiting", hold_bad, 0);
    repeat (5) @(negedge clk);
    chk(done == !exp_err && !(done && error), "R11", "status held", int'(done), int'(!exp_err));
  endtask

  initial begin
    n_chk = 0; n_bad = 0; desc_bad = 0; hold_bad = 0;
    stall_mode = 0;
    repeat (3) @(negedge clk);
    chk(!busy, "R1", "busy after reset", int'(busy), 0);
    chk(!done, "R1", "done after reset", int'(done), 0);
    chk(!error, "R1", "error after reset", int'(error), 0);
    chk(!mem_req, "R1", "mem_req after reset", int'(mem_req), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R5: period-3 pattern, overlapping copies at minimum distance
    for (int j = 0; j < 60; j++) plain[j] = (j < 3) ? 8'(8'h11 * (j + 1)) : plain[j-3];
    run_case("R5", 60, 16'h0400, 4098, 0, 0);

    // R3: random head then period 7, memory stalls, mid-run start ignored (R11)
    stall_mode = 1;
    begin
      logic [7:0] s;
      s = 8'h9D;
      for (int j = 0; j < 200; j++) begin
        if (j < 16) begin s = {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]}; plain[j] = s; end
        else plain[j] = plain[j-7];
      end
    end
    run_case("R3", 200, 16'h0800, 4098, 0, 1);

    // R4: long runs -> maximum length field
    for (int j = 0; j < 240; j++) plain[j] = 8'((j / 30) * 37 + 5);
    run_case("R4", 240, 16'h0300, 4098, 0, 0);

    // R4: match only at distance 4098 (maximum displacement field)
    stall_mode = 0;
    begin
      logic [7:0] s;
      s = 8'h3B;
      for (int j = 0; j < 4138; j++) begin
        if (j < 40) begin s = {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]}; plain[j] = s | 8'h01; end
        else if (j < 4098) plain[j] = 8'h00;
        else plain[j] = plain[j-4098];
      end
    end
    run_case("R4", 4138, 16'h0900, 4098, 1, 0);
    chk(used_far, "R4", "far distance used", int'(used_far), 1);

    // R8: literals only, next flag needed at base
    cs[0] = 8'h00;
    for (int k = 1; k < 9; k++) cs[k] = 8'(8'hA0 + k);
    cn = 9;
    launch_run(16'h0100, 0, 0);
    chk(error && !done, "R8", "error on read below base", int'(error), 1);
    begin
      int bad;
      bad = 0;
      for (int k = 0; k < 8; k++) if (mem[16'h0100-1-k] != 8'(8'hA1 + k)) bad++;
      chk(bad == 0, "R8", "literals written before stop", bad, 0);
    end

    // R7: overlapping copy overruns the consumed input
    cs[0] = 8'h1F; cs[1] = 8'h61; cs[2] = 8'h62; cs[3] = 8'h63; cs[4] = 8'hF0; cs[5] = 8'h00;
    cn = 6;
    launch_run(16'h0100, 0, 0);
    chk(error && !done, "R7", "error on overwrite", int'(error), 1);
    chk(mem[16'h00FC] == 8'h61 && mem[16'h00FB] == 8'h62 && mem[16'h00FA] == 8'h63,
        "R7", "copied bytes before stop", int'(mem[16'h00FA]), 8'h63);
    chk(mem[16'h00F9] == fillv(16'h00F9), "R7", "prefix byte untouched", int'(mem[16'h00F9]), int'(fillv(16'h00F9)));

    // R9: copy source above the output top
    cs[0] = 8'h80; cs[1] = 8'h00; cs[2] = 8'h00;
    cn = 3;
    launch_run(16'h0100, 0, 0);
    chk(error && !done, "R9", "error on source above top", int'(error), 1);
    chk(mem[16'h00FF] == 8'h80, "R9", "no write performed", int'(mem[16'h00FF]), 8'h80);

    // R11: restart after error
    for (int j = 0; j < 60; j++) plain[j] = (j < 3) ? 8'(8'h11 * (j + 1)) : plain[j-3];
    run_case("R11", 60, 16'h0400, 4098, 0, 0);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule